// File: doc/BRIEF.md
# I2C SCL Phase Timer with Clock-Stretch Wait

This block is the down-counter that times each half-period of SCL for an I2C master. A sequencer asks it to reload from a 7-bit period value. The counter then steps down once on every pulse of a phase-enable input, which arrives twice per instruction cycle. When the count runs out, the block emits a one-clock timeout pulse and parks at zero. The sequencer uses that pulse to toggle SCL or SDA and then requests the next reload.

The block also handles clock stretching. When the master has just released SCL, it sets a wait flag on the reload request. If the sampled SCL is still low because a slave is holding it, the block neither loads nor counts. It loads the period value only on the first clock where SCL is seen high, so a stretched clock makes the phase longer and the slave is never overrun. A suspend input freezes the block until the next reload request.

Top module: `scl_phase_timer`

## Requirements
- R1: While reset is asserted, and after it is released, the count output is 0 and the timeout output is 0. The block stays idle: phase enables change nothing until a reload request arrives.
- R2: A reload request with the wait flag at 0 copies the 7-bit period input into the count. The new count appears at the clock edge that samples the request.
- R3: Once loaded, the count falls by exactly one at every clock edge where the phase enable is 1. At edges where the phase enable is 0, the count is unchanged.
- R4: At the phase-enable edge where the count goes from 1 to 0, the timeout output is 1 for exactly one clock. After that the count stays at 0 and does not wrap, and later phase enables give no further timeouts until the next reload.
- R5: A period value of 0 gives the timeout at the first phase-enable edge after the load. The count stays at 0.
- R6: A reload request with the wait flag at 1, made while sampled SCL is 0, loads nothing and starts no counting. The count keeps its old value through any number of phase enables until the first clock where SCL is sampled 1. At that clock the period value is loaded.
- R7: A suspend pulse freezes the count and masks timeouts. Phase enables then have no effect until a reload request arrives.
- R8: A reload request in the same clock as a phase enable loads the period value, and no decrement happens in that clock.
- R9: A reload request with the wait flag at 1, made while sampled SCL is already 1, loads at once, exactly as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| phase_en_i | input | 1 | Phase enable, two pulses per instruction cycle |
| period_i | input | 7 | Reload value for the counter |
| reload_i | input | 1 | Reload request from the sequencer |
| await_high_i | input | 1 | With reload_i: wait for SCL to be sampled high before loading |
| suspend_i | input | 1 | Freeze the counter until the next reload |
| scl_i | input | 1 | Sampled SCL line level |
| timeout_o | output | 1 | One-clock pulse when the count expires |
| count_o | output | 7 | Current count |

## Verification
A corrupted count register or a wrong control state shows on count_o at the very next clock edge. The bench compares count_o against an arithmetic model after every clock. If the block drops out of the counting state, or leaves the wait state too early, the count freezes or jumps one edge before or after the model. A wrong timeout condition moves the timeout_o pulse by at least one phase-enable period. It may also repeat the pulse at zero, and the per-cycle comparison catches that within one clock.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;
  typedef enum logic [1:0] {
    TMR_IDLE  = 2'd0,
    TMR_AWAIT = 2'd1,
    TMR_COUNT = 2'd2,
    TMR_PARK  = 2'd3
  } tmr_state_e;
endpackage

// File: rtl/scl_timer_rst_sync.sv
module scl_timer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/scl_timer_ctrl.sv
module scl_timer_ctrl
  import scl_timer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       phase_en_i,
  input  logic       reload_i,
  input  logic       await_high_i,
  input  logic       suspend_i,
  input  logic       scl_i,
  input  logic       at_last_i,
  output tmr_state_e state_o,
  output logic       load_en_o,
  output logic       dec_en_o,
  output logic       fire_o
);
  tmr_state_e state_q, state_d;
  logic       req_load;
  logic       wait_load;

  always_comb begin
    req_load  = reload_i && (!await_high_i || scl_i);
    wait_load = !reload_i && !suspend_i && (state_q == TMR_AWAIT) && scl_i;
    load_en_o = req_load || wait_load;
    dec_en_o  = !reload_i && !suspend_i && (state_q == TMR_COUNT) && phase_en_i;
    fire_o    = dec_en_o && at_last_i;
  end

  always_comb begin
    state_d = state_q;
    if (reload_i) begin
      state_d = req_load ? TMR_COUNT : TMR_AWAIT;
    end else if (suspend_i) begin
      state_d = TMR_IDLE;
    end else begin
      case (state_q)
        TMR_AWAIT: if (scl_i) state_d = TMR_COUNT;
        TMR_COUNT: if (fire_o) state_d = TMR_PARK;
        default:   state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TMR_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_PARK_AFTER_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (state_q == TMR_PARK)); // R4
  AST_NO_LOAD_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == TMR_AWAIT) && !reload_i && !scl_i) |-> !load_en_o); // R6
endmodule

// File: rtl/scl_timer_counter.sv
module scl_timer_counter #(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_en_i,
  input  logic          dec_en_i,
  input  logic          fire_i,
  input  logic [CW-1:0] period_i,
  output logic [CW-1:0] count_o,
  output logic          at_last_o,
  output logic          timeout_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tmo_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load_en_i)                       cnt_d = period_i;
    else if (dec_en_i && cnt_q != '0)    cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tmo_q <= fire_i;
    end
  end

  assign count_o   = cnt_q;
  assign at_last_o = (cnt_q <= ONE);
  assign timeout_o = tmo_q;

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_en_i) |=> (cnt_q == '0)); // R4
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_en_i && !load_en_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE)); // R3
  AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> (cnt_q == $past(period_i))); // R2
  AST_TMO_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_q |-> (cnt_q == '0)); // R4
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
  import scl_timer_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          phase_en_i,
  input  logic [CW-1:0] period_i,
  input  logic          reload_i,
  input  logic          await_high_i,
  input  logic          suspend_i,
  input  logic          scl_i,
  output logic          timeout_o,
  output logic [CW-1:0] count_o
);
  logic       rst_n;
  tmr_state_e state;
  logic       load_en, dec_en, fire, at_last;

  scl_timer_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  scl_timer_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .phase_en_i   (phase_en_i),
    .reload_i     (reload_i),
    .await_high_i (await_high_i),
    .suspend_i    (suspend_i),
    .scl_i        (scl_i),
    .at_last_i    (at_last),
    .state_o      (state),
    .load_en_o    (load_en),
    .dec_en_o     (dec_en),
    .fire_o       (fire)
  );

  scl_timer_counter #(.CW(CW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .load_en_i (load_en),
    .dec_en_i  (dec_en),
    .fire_i    (fire),
    .period_i  (period_i),
    .count_o   (count_o),
    .at_last_o (at_last),
    .timeout_o (timeout_o)
  );

  AST_AWAIT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((state == TMR_AWAIT) && !reload_i && !scl_i) |=> ($stable(count_o) && !timeout_o)); // R6
  AST_IDLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((state == TMR_IDLE) && !reload_i) |=> ($stable(count_o) && !timeout_o)); // R7
  AST_RELOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reload_i && !await_high_i) |=> (count_o == $past(period_i) && !timeout_o)); // R8
endmodule

// File: tb/scl_phase_timer_test.sv
module scl_phase_timer_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, req, wt, susp, scl;
  logic [6:0] rv;
  logic       tmo;
  logic [6:0] cnt;

  int n_run  = 0;
  int n_fail = 0;

  int       e_st;   // 0 idle, 1 await, 2 count, 3 park
  int       e_cnt;
  bit       e_tmo;

  always #5 clk = ~clk;

  scl_phase_timer uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .phase_en_i   (tick),
    .period_i     (rv),
    .reload_i     (req),
    .await_high_i (wt),
    .suspend_i    (susp),
    .scl_i        (scl),
    .timeout_o    (tmo),
    .count_o      (cnt)
  );

  task automatic check(string tag);
    n_run++;
    if (int'(cnt) != e_cnt || tmo != e_tmo) begin
      n_fail++;
      $display("FAIL %s: count=%0d timeout=%0b expected count=%0d timeout=%0b",
               tag, cnt, tmo, e_cnt, e_tmo);
    end
  endtask

  task automatic step(string tag);
    e_tmo = 1'b0;
    if (req) begin
      if (!wt || scl) begin e_cnt = int'(rv); e_st = 2; end
      else e_st = 1;
    end else if (susp) begin
      e_st = 0;
    end else if (e_st == 1 && scl) begin
      e_cnt = int'(rv); e_st = 2;
    end else if (e_st == 2 && tick) begin
      if (e_cnt <= 1) begin e_cnt = 0; e_tmo = 1'b1; e_st = 3; end
      else e_cnt = e_cnt - 1;
    end
    @(posedge clk); #1;
    check(tag);
  endtask

  task automatic idle_inputs();
    tick = 0; req = 0; wt = 0; susp = 0; scl = 1;
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle_inputs(); rv = 7'd0;
    e_st = 0; e_cnt = 0; e_tmo = 0;
    rst_n = 0;
    #23;
    check("R1");
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R1");
    tick = 1;
    for (int i = 0; i < 5; i++) step("R1");
    tick = 0;

    // R2 R3 R4 R5: sweep every period value and two enable spacings
    for (int k = 1; k <= 2; k++) begin
      for (int v = 0; v < 128; v++) begin
        rv = 7'(v); req = 1; tick = 0;
        step("R2");
        req = 0;
        for (int i = 0; i < (v + 3) * k; i++) begin
          tick = ((i % k) == k - 1);
          step(v == 0 ? "R5" : "R4");
        end
        tick = 0;
        step("R3");
      end
    end

    // R8: reload collides with a phase enable
    rv = 7'd20; req = 1; step("R2"); req = 0;
    tick = 1;
    for (int i = 0; i < 5; i++) step("R3");
    rv = 7'd9; req = 1; step("R8"); req = 0;
    for (int i = 0; i < 12; i++) step("R4");
    tick = 0;

    // R6: stretch lengths swept, SCL held low by a slave
    for (int n = 0; n <= 10; n++) begin
      rv = 7'(3 + n); req = 1; step("R2"); req = 0;
      tick = 1;
      for (int i = 0; i < 2; i++) step("R3");
      rv = 7'd50; req = 1; wt = 1; scl = 0; step("R6");
      req = 0; wt = 0;
      for (int i = 0; i < n; i++) step("R6");
      scl = 1; step("R6");
      for (int i = 0; i < 4; i++) step("R3");
      tick = 0;
    end

    // R9: wait flag with SCL already high
    rv = 7'd11; req = 1; wt = 1; scl = 1; step("R9");
    req = 0; wt = 0; tick = 1;
    for (int i = 0; i < 14; i++) step("R4");
    tick = 0;

    // R7: suspend mid-count
    rv = 7'd40; req = 1; step("R2"); req = 0;
    tick = 1;
    for (int i = 0; i < 5; i++) step("R3");
    susp = 1; step("R7"); susp = 0;
    for (int i = 0; i < 60; i++) step("R7");
    rv = 7'd2; req = 1; step("R7"); req = 0;
    for (int i = 0; i < 4; i++) step("R4");
    tick = 0;

    // R1: asynchronous reset mid-count
    rv = 7'd30; req = 1; step("R2"); req = 0; tick = 1;
    for (int i = 0; i < 3; i++) step("R3");
    #2 rst_n = 0; #1;
    e_st = 0; e_cnt = 0; e_tmo = 0;
    check("R1");
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < 4; i++) step("R1");
    idle_inputs();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule